// File: doc/BRIEF.md
# Floating-point register stack controller

This block holds the eight 80-bit registers of a floating-point register stack together with a rotating 3-bit top-of-stack pointer and a 2-bit tag per physical register. Instructions name registers relative to the top of the stack: ST(i) is the register i places below the top. The block performs one register-to-register stack command per strobe: load with push, exchange, conditional move, store with or without pop, free with or without pop, initialise, and push of an externally supplied value. The last command is how register payloads enter the stack. Register payloads are opaque and are never interpreted.

The block checks tags to find empty-register underflow and full-stack overflow. When a command hits an empty operand, the invalid-operation mask bit picks the response. With the mask set, the block substitutes a value in place. With the mask clear, it raises an exception strobe and leaves the state as it was. Each accepted command finishes in one clock. The new state and all result strobes appear in the cycle after the command edge. A combinational read port returns ST(rd_idx) from the current state.

Top module: `fpstk_top`

## Requirements
- R1: ST(k) maps to physical register (TOP + k) mod 8. The tag of physical register r is tag_word[2r+1:2r], with codes 00 valid, 01 zero, 10 special and 11 empty. rd_data is ST(rd_idx). After reset, tag_word is 16'hFFFF and top is 0.
- R2: Opcode 0 (initialise) sets every tag to empty and TOP to 0, and pulses only done.
- R3: Opcode 8 (push value) decrements TOP modulo 8 and writes push_data with tag push_tag into the new ST(0). Opcodes 8 and 1 first check for overflow, which is a non-empty tag at physical (TOP-1) mod 8. On overflow they pulse stk_fault and change nothing.
- R4: Opcode 1 (load) with a non-empty ST(i) pushes a copy of ST(i) and gives the new ST(0) that register's tag.
- R5: Opcode 1 with an empty ST(i) pulses stk_fault. With inv_mask=1, ST(0) becomes 80'hFFFF_C000_0000_0000_0000 with tag 10 and TOP is unchanged. With inv_mask=0, inv_exc also pulses and the state is unchanged. inv_exc never pulses without stk_fault.
- R6: Opcode 2 (exchange) with ST(0) and ST(i) both non-empty swaps their data and tags and pulses c1_clr.
- R7: Opcode 2 with any empty operand pulses stk_fault. With inv_mask=0, inv_exc also pulses and nothing changes. With inv_mask=1 and one operand empty, the non-empty value and its tag are copied into the empty one and the source is kept. With inv_mask=1 and both empty, both receive the indefinite value with tag 10.
- R8: Opcode 3 (conditional move) evaluates cc_sel[1:0] as 0: CF, 1: ZF, 2: CF|ZF, 3: PF, and cc_sel[2]=1 inverts the result. A false condition changes nothing and pulses only done.
- R9: A true conditional move copies ST(i) and its tag into ST(0). If ST(i) is empty, it instead pulses stk_fault and c1_clr, leaves ST(0) unchanged, and pulses inv_exc when inv_mask=0.
- R10: Opcode 4 copies ST(0) and its tag into ST(i). Opcode 5 does the same and then pops: the old ST(0) tag becomes empty and TOP increments modulo 8.
- R11: Opcode 6 marks ST(i) empty without changing TOP or data. Opcode 7 also pops.
- R12: done pulses for exactly one cycle after each accepted command. Opcodes 9 to 15 change nothing and pulse only done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_idx | input | 3 | Relative register index i |
| cc_sel | input | 3 | Conditional-move condition select |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_pf | input | 1 | Parity flag |
| inv_mask | input | 1 | Invalid-operation mask |
| push_data | input | 80 | Payload for push value |
| push_tag | input | 2 | Tag for push value |
| rd_idx | input | 3 | Relative read index |
| rd_data | output | 80 | Contents of ST(rd_idx) |
| tag_word | output | 16 | Packed tags by physical register |
| top | output | 3 | Top-of-stack pointer |
| done | output | 1 | Command complete |
| stk_fault | output | 1 | Stack overflow or underflow |
| inv_exc | output | 1 | Unmasked invalid exception |
| c1_clr | output | 1 | Condition bit C1 clear |

## Verification
A wrong top pointer shows at the ports immediately, through top itself and through rd_data returning the wrong neighbour. It also shows one command later, when a stale tag triggers a spurious or missed fault. A tag written to the wrong physical slot shows in tag_word in the cycle after the command. A lost data write stays hidden until ST(i) is read or exchanged. For that reason every command is followed by a read-port probe of a register it may have touched. Under each mask setting, the fault strobes are compared against the tag state the command saw.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int PTR_W = 3;
  localparam int NREG  = 1 << PTR_W;
  localparam int TAG_W = 2;
  localparam int TWD_W = TAG_W * NREG;

  localparam logic [3:0] OP_INIT      = 4'd0;
  localparam logic [3:0] OP_LOAD      = 4'd1;
  localparam logic [3:0] OP_XCHG      = 4'd2;
  localparam logic [3:0] OP_CMOV      = 4'd3;
  localparam logic [3:0] OP_STORE     = 4'd4;
  localparam logic [3:0] OP_STORE_POP = 4'd5;
  localparam logic [3:0] OP_FREE      = 4'd6;
  localparam logic [3:0] OP_FREE_POP  = 4'd7;
  localparam logic [3:0] OP_PUSHV     = 4'd8;

  localparam logic [TAG_W-1:0] TAG_VALID   = 2'b00;
  localparam logic [TAG_W-1:0] TAG_SPECIAL = 2'b10;
  localparam logic [TAG_W-1:0] TAG_EMPTY   = 2'b11;

  typedef enum logic [1:0] {SRC_ST0, SRC_STI, SRC_EXT, SRC_QNAN} src_e;

  typedef struct packed {
    logic             den;
    logic             ten;
    logic [PTR_W-1:0] idx;
    src_e             src;
    logic [TAG_W-1:0] tag;
  } wr_t;
endpackage

// File: rtl/fpstk_cond.sv
module fpstk_cond (
  input  logic [2:0] cc_sel,
  input  logic       cf,
  input  logic       zf,
  input  logic       pf,
  output logic       take
);
  logic base;

  always_comb begin
    unique case (cc_sel[1:0])
      2'd0:    base = cf;
      2'd1:    base = zf;
      2'd2:    base = cf | zf;
      default: base = pf;
    endcase
    take = base ^ cc_sel[2];
  end
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
  import fpstk_pkg::*;
(
  input  logic             valid,
  input  logic [3:0]       op,
  input  logic [PTR_W-1:0] idx,
  input  logic             take,
  input  logic             inv_mask,
  input  logic [PTR_W-1:0] top,
  input  logic [TWD_W-1:0] tags,
  output wr_t              wa,
  output wr_t              wb,
  output logic [PTR_W-1:0] top_nxt,
  output logic             pop_en,
  output logic             init_en,
  output logic             fault,
  output logic             inv,
  output logic             c1clr
);
  logic [PTR_W-1:0] s0, si, sp;
  logic [TAG_W-1:0] t0, ti;
  logic             e0, ei, ep;

  function automatic wr_t mk(input logic [PTR_W-1:0] r, input src_e s,
                             input logic [TAG_W-1:0] t);
    wr_t w;
    w.den = 1'b1;
    w.ten = 1'b1;
    w.idx = r;
    w.src = s;
    w.tag = t;
    return w;
  endfunction

  always_comb begin
    s0 = top;
    si = top + idx;
    sp = top - 3'd1;
    t0 = tags[{s0, 1'b0} +: TAG_W];
    ti = tags[{si, 1'b0} +: TAG_W];
    e0 = (t0 == TAG_EMPTY);
    ei = (ti == TAG_EMPTY);
    ep = (tags[{sp, 1'b0} +: TAG_W] == TAG_EMPTY);
  end

  always_comb begin
    wa      = '0;
    wb      = '0;
    top_nxt = top;
    pop_en  = 1'b0;
    init_en = 1'b0;
    fault   = 1'b0;
    inv     = 1'b0;
    c1clr   = 1'b0;
    if (valid) begin
      case (op)
        OP_INIT: begin
          init_en = 1'b1;
          top_nxt = '0;
        end
        OP_LOAD, OP_PUSHV: begin
          if (!ep) begin
            fault = 1'b1;
          end else if (op == OP_PUSHV) begin
            wa      = mk(sp, SRC_EXT, TAG_VALID);
            top_nxt = sp;
          end else if (!ei) begin
            wa      = mk(sp, SRC_STI, ti);
            top_nxt = sp;
          end else begin
            fault = 1'b1;
            if (inv_mask) wa = mk(s0, SRC_QNAN, TAG_SPECIAL);
            else          inv = 1'b1;
          end
        end
        OP_XCHG: begin
          if (!e0 && !ei) begin
            c1clr = 1'b1;
            wa    = mk(s0, SRC_STI, ti);
            if (idx != '0) wb = mk(si, SRC_ST0, t0);
          end else begin
            fault = 1'b1;
            if (!inv_mask) begin
              inv = 1'b1;
            end else if (e0 && ei) begin
              wa = mk(s0, SRC_QNAN, TAG_SPECIAL);
              if (idx != '0) wb = mk(si, SRC_QNAN, TAG_SPECIAL);
            end else if (e0) begin
              wa = mk(s0, SRC_STI, ti);
            end else begin
              wa = mk(si, SRC_ST0, t0);
            end
          end
        end
        OP_CMOV: begin
          if (take) begin
            if (!ei) begin
              wa = mk(s0, SRC_STI, ti);
            end else begin
              fault = 1'b1;
              c1clr = 1'b1;
              inv   = !inv_mask;
            end
          end
        end
        OP_STORE, OP_STORE_POP: begin
          wa = mk(si, SRC_ST0, t0);
          if (op == OP_STORE_POP) begin
            pop_en  = 1'b1;
            top_nxt = top + 3'd1;
          end
        end
        OP_FREE, OP_FREE_POP: begin
          wa.ten = 1'b1;
          wa.idx = si;
          wa.tag = TAG_EMPTY;
          if (op == OP_FREE_POP) begin
            pop_en  = 1'b1;
            top_nxt = top + 3'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (wa.den && wb.den) begin
      AST_WR_DISTINCT: assert (wa.idx != wb.idx); // R6
    end
    if (inv) begin
      AST_INV_WITH_FAULT: assert (fault); // R5
    end
  end
endmodule

// File: rtl/fpstk_top.sv
module fpstk_top
  import fpstk_pkg::*;
#(
  parameter int                DATA_W = 80,
  parameter logic [DATA_W-1:0] QNAN   = 80'hFFFF_C000_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [PTR_W-1:0]  cmd_idx,
  input  logic [2:0]        cc_sel,
  input  logic              flag_cf,
  input  logic              flag_zf,
  input  logic              flag_pf,
  input  logic              inv_mask,
  input  logic [DATA_W-1:0] push_data,
  input  logic [TAG_W-1:0]  push_tag,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [TWD_W-1:0]  tag_word,
  output logic [PTR_W-1:0]  top,
  output logic              done,
  output logic              stk_fault,
  output logic              inv_exc,
  output logic              c1_clr
);
  logic [1:0]        rst_sync_q;
  logic              rst_ns;
  logic [PTR_W-1:0]  top_q, top_d;
  logic [TWD_W-1:0]  tags_q, tags_d;
  logic [DATA_W-1:0] data_q [NREG];
  logic [DATA_W-1:0] data_d [NREG];
  logic [NREG-1:0]   data_en;
  logic [DATA_W-1:0] a_val, b_val;
  logic [PTR_W-1:0]  si;
  logic              take, pop_en, init_en, fault, inv, c1clr;
  logic              done_q, fault_q, inv_q, c1_q;
  wr_t               wa, wb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  fpstk_cond u_cond (
    .cc_sel (cc_sel),
    .cf     (flag_cf),
    .zf     (flag_zf),
    .pf     (flag_pf),
    .take   (take)
  );

  fpstk_ctrl u_ctrl (
    .valid    (cmd_valid),
    .op       (cmd_op),
    .idx      (cmd_idx),
    .take     (take),
    .inv_mask (inv_mask),
    .top      (top_q),
    .tags     (tags_q),
    .wa       (wa),
    .wb       (wb),
    .top_nxt  (top_d),
    .pop_en   (pop_en),
    .init_en  (init_en),
    .fault    (fault),
    .inv      (inv),
    .c1clr    (c1clr)
  );

  function automatic logic [DATA_W-1:0] pick(input src_e s,
                                             input logic [DATA_W-1:0] d0,
                                             input logic [DATA_W-1:0] di,
                                             input logic [DATA_W-1:0] dx);
    case (s)
      SRC_ST0: return d0;
      SRC_STI: return di;
      SRC_EXT: return dx;
      default: return QNAN;
    endcase
  endfunction

  always_comb begin
    si    = top_q + cmd_idx;
    a_val = pick(wa.src, data_q[top_q], data_q[si], push_data);
    b_val = pick(wb.src, data_q[top_q], data_q[si], push_data);
  end

  always_comb begin
    tags_d = tags_q;
    if (wa.ten) tags_d[{wa.idx, 1'b0} +: TAG_W] = (wa.src == SRC_EXT) ? push_tag : wa.tag;
    if (wb.ten) tags_d[{wb.idx, 1'b0} +: TAG_W] = wb.tag;
    if (pop_en) tags_d[{top_q, 1'b0} +: TAG_W] = TAG_EMPTY;
    if (init_en) tags_d = '1;
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit_a, hit_b;
    assign hit_a      = wa.den && (wa.idx == PTR_W'(r));
    assign hit_b      = wb.den && (wb.idx == PTR_W'(r));
    assign data_en[r] = hit_a | hit_b;
    assign data_d[r]  = hit_a ? a_val : b_val;
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (data_en[r]) data_q[r] <= data_d[r];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      top_q   <= '0;
      tags_q  <= '1;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      inv_q   <= 1'b0;
      c1_q    <= 1'b0;
    end else begin
      if (cmd_valid) begin
        top_q  <= top_d;
        tags_q <= tags_d;
      end
      done_q  <= cmd_valid;
      fault_q <= fault;
      inv_q   <= inv;
      c1_q    <= c1clr;
    end
  end

  assign rd_data   = data_q[top_q + rd_idx];
  assign tag_word  = tags_q;
  assign top       = top_q;
  assign done      = done_q;
  assign stk_fault = fault_q;
  assign inv_exc   = inv_q;
  assign c1_clr    = c1_q;

  logic [PTR_W-1:0] below;
  logic             ovf_pre;
  assign below   = top_q - 3'd1;
  assign ovf_pre = tags_q[{below, 1'b0} +: TAG_W] != TAG_EMPTY;

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_valid && cmd_op == OP_INIT |=> tag_word == '1 && top == '0); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_valid && (cmd_op == OP_LOAD || cmd_op == OP_PUSHV) && ovf_pre
    |=> stk_fault && $stable(top) && $stable(tag_word)); // R3
  AST_FREE_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_valid && cmd_op == OP_FREE |=> $stable(top)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_valid |=> done); // R12
  AST_STROBE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_ns)
    (stk_fault || inv_exc || c1_clr) |-> done); // R12
  AST_INV_IMPLIES_FAULT: assert property (@(posedge clk) disable iff (!rst_ns)
    inv_exc |-> stk_fault); // R5
endmodule

// File: tb/tb_fpstk_top.sv
module tb_fpstk_top;
  localparam logic [79:0] QN = 80'hFFFF_C000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0, cc_sel = '0, rd_idx = '0;
  logic        flag_cf = 0, flag_zf = 0, flag_pf = 0, inv_mask = 0;
  logic [79:0] push_data = '0;
  logic [1:0]  push_tag = '0;
  logic [79:0] rd_data;
  logic [15:0] tag_word;
  logic [2:0]  top;
  logic        done, stk_fault, inv_exc, c1_clr;

  always #2 clk = ~clk;

  fpstk_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cc_sel(cc_sel), .flag_cf(flag_cf), .flag_zf(flag_zf),
    .flag_pf(flag_pf), .inv_mask(inv_mask), .push_data(push_data),
    .push_tag(push_tag), .rd_idx(rd_idx), .rd_data(rd_data),
    .tag_word(tag_word), .top(top), .done(done), .stk_fault(stk_fault),
    .inv_exc(inv_exc), .c1_clr(c1_clr)
  );

  typedef struct {
    logic [2:0]  top;
    logic [15:0] tags;
    logic [2:0]  strb;
    logic        chk;
    logic [79:0] data;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          vectors = 0;
  int          miscompares = 0;
  bit          finished = 0;
  logic [79:0] m_data [8];
  logic [1:0]  m_tag [8];
  logic [2:0]  m_top;

  function automatic logic [15:0] m_pack();
    logic [15:0] w;
    for (int r = 0; r < 8; r++) w[2*r +: 2] = m_tag[r];
    return w;
  endfunction

  task automatic model(input logic [3:0] op, input logic [2:0] i, input logic [2:0] cc,
                       input logic cf, input logic zf, input logic pf, input logic msk,
                       input logic [79:0] wd, input logic [1:0] wt,
                       output logic [2:0] strb);
    logic [2:0]  a, b, p;
    logic        base, take, e0, ei, fault, inv, c1;
    logic [79:0] td;
    logic [1:0]  tt;
    fault = 0; inv = 0; c1 = 0;
    a = m_top; b = m_top + i; p = m_top - 3'd1;
    case (cc[1:0])
      2'd0: base = cf;
      2'd1: base = zf;
      2'd2: base = cf | zf;
      default: base = pf;
    endcase
    take = base ^ cc[2];
    e0 = m_tag[a] == 2'b11;
    ei = m_tag[b] == 2'b11;
    case (op)
      4'd0: begin
        for (int r = 0; r < 8; r++) m_tag[r] = 2'b11;
        m_top = 0;
      end
      4'd1: begin
        if (m_tag[p] != 2'b11) fault = 1;
        else if (!ei) begin
          m_data[p] = m_data[b]; m_tag[p] = m_tag[b]; m_top = p;
        end else begin
          fault = 1;
          if (msk) begin m_data[a] = QN; m_tag[a] = 2'b10; end
          else inv = 1;
        end
      end
      4'd2: begin
        if (!e0 && !ei) begin
          td = m_data[a]; tt = m_tag[a];
          m_data[a] = m_data[b]; m_tag[a] = m_tag[b];
          m_data[b] = td; m_tag[b] = tt; c1 = 1;
        end else begin
          fault = 1;
          if (!msk) inv = 1;
          else if (e0 && ei) begin
            m_data[a] = QN; m_tag[a] = 2'b10; m_data[b] = QN; m_tag[b] = 2'b10;
          end else if (e0) begin
            m_data[a] = m_data[b]; m_tag[a] = m_tag[b];
          end else begin
            m_data[b] = m_data[a]; m_tag[b] = m_tag[a];
          end
        end
      end
      4'd3: begin
        if (take) begin
          if (!ei) begin m_data[a] = m_data[b]; m_tag[a] = m_tag[b]; end
          else begin fault = 1; c1 = 1; inv = !msk; end
        end
      end
      4'd4, 4'd5: begin
        m_data[b] = m_data[a]; m_tag[b] = m_tag[a];
        if (op == 4'd5) begin m_tag[a] = 2'b11; m_top = a + 3'd1; end
      end
      4'd6, 4'd7: begin
        m_tag[b] = 2'b11;
        if (op == 4'd7) begin m_tag[a] = 2'b11; m_top = a + 3'd1; end
      end
      4'd8: begin
        if (m_tag[p] != 2'b11) fault = 1;
        else begin m_data[p] = wd; m_tag[p] = wt; m_top = p; end
      end
      default: ;
    endcase
    strb = {fault, inv, c1};
  endtask

  task automatic cmd(input logic [3:0] op, input logic [2:0] i, input logic [2:0] cc,
                     input logic [2:0] flg, input logic msk, input logic [79:0] wd,
                     input logic [1:0] wt, input logic [2:0] probe, input string req);
    exp_t        e;
    logic [2:0]  s;
    logic [2:0]  pp;
    @(negedge clk);
    cmd_op = op; cmd_idx = i; cc_sel = cc;
    {flag_cf, flag_zf, flag_pf} = flg; inv_mask = msk;
    push_data = wd; push_tag = wt; rd_idx = probe; cmd_valid = 1'b1;
    model(op, i, cc, flg[2], flg[1], flg[0], msk, wd, wt, s);
    pp     = m_top + probe;
    e.top  = m_top;
    e.tags = m_pack();
    e.strb = s;
    e.chk  = m_tag[pp] != 2'b11;
    e.data = m_data[pp];
    e.req  = req;
    sb.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      exp_t e;
      bit   bad;
      bad = 0;
      if (sb.size() == 0) begin
        $display("FAIL R12: done with no command pending (actual 1, expected 0)");
        miscompares++;
      end else begin
        e = sb.pop_front();
        vectors++;
        if (top !== e.top) begin
          bad = 1; $display("FAIL %s: top actual %0d expected %0d", e.req, top, e.top);
        end
        if (tag_word !== e.tags) begin
          bad = 1; $display("FAIL %s: tag_word actual %h expected %h", e.req, tag_word, e.tags);
        end
        if ({stk_fault, inv_exc, c1_clr} !== e.strb) begin
          bad = 1; $display("FAIL %s: fault/inv/c1 actual %b expected %b", e.req,
                            {stk_fault, inv_exc, c1_clr}, e.strb);
        end
        if (e.chk && rd_data !== e.data) begin
          bad = 1; $display("FAIL %s: rd_data actual %h expected %h", e.req, rd_data, e.data);
        end
        if (bad) miscompares++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: run not finished (actual hung, expected done)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 8; r++) begin m_data[r] = '0; m_tag[r] = 2'b11; end
    m_top = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    vectors++;
    if (top !== 3'd0 || tag_word !== 16'hFFFF || done !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: reset state actual top %0d tags %h done %b expected 0 ffff 0",
               top, tag_word, done);
    end

    cmd(4'd8, 0, 0, 0, 0, 80'hA, 2'b00, 0, "R3");
    cmd(4'd8, 0, 0, 0, 0, 80'hB, 2'b01, 0, "R3");
    cmd(4'd8, 0, 0, 0, 0, 80'hC, 2'b10, 2, "R1");
    cmd(4'd1, 2, 0, 0, 0, '0, 0, 0, "R4");
    cmd(4'd2, 1, 0, 0, 0, '0, 0, 1, "R6");
    cmd(4'd2, 0, 0, 0, 0, '0, 0, 0, "R6");
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 8; f += 3) begin
        cmd(4'd8, 0, 0, 0, 0, 80'h1000 + 80'(cc * 8 + f), 2'b00, 3, "R3");
        cmd(4'd3, 3, 3'(cc), 3'(f), 0, '0, 0, 0, "R8");
        cmd(4'd7, 0, 0, 0, 0, '0, 0, 0, "R11");
      end
    end
    cmd(4'd6, 2, 0, 0, 0, '0, 0, 2, "R11");
    cmd(4'd2, 2, 0, 0, 0, '0, 0, 2, "R7");
    cmd(4'd2, 2, 0, 0, 1, '0, 0, 2, "R7");
    cmd(4'd6, 0, 0, 0, 0, '0, 0, 1, "R11");
    cmd(4'd2, 1, 0, 0, 1, '0, 0, 0, "R7");
    cmd(4'd6, 0, 0, 0, 0, '0, 0, 0, "R11");
    cmd(4'd6, 2, 0, 0, 0, '0, 0, 0, "R11");
    cmd(4'd2, 2, 0, 0, 1, '0, 0, 2, "R7");
    cmd(4'd6, 5, 0, 0, 0, '0, 0, 0, "R11");
    cmd(4'd3, 5, 0, 3'b100, 1, '0, 0, 0, "R9");
    cmd(4'd3, 5, 0, 3'b100, 0, '0, 0, 0, "R9");
    cmd(4'd3, 1, 3'd6, 3'b000, 0, '0, 0, 0, "R9");
    cmd(4'd1, 5, 0, 0, 0, '0, 0, 0, "R5");
    cmd(4'd1, 5, 0, 0, 1, '0, 0, 0, "R5");
    cmd(4'd4, 5, 0, 0, 0, '0, 0, 5, "R10");
    cmd(4'd5, 1, 0, 0, 0, '0, 0, 0, "R10");
    cmd(4'd5, 0, 0, 0, 0, '0, 0, 0, "R10");
    cmd(4'd9, 1, 0, 0, 0, '0, 0, 0, "R12");
    cmd(4'd15, 2, 0, 0, 1, '0, 0, 0, "R12");
    cmd(4'd0, 0, 0, 0, 0, '0, 0, 0, "R2");
    for (int k = 0; k < 8; k++)
      cmd(4'd8, 0, 0, 0, 0, 80'h2000 + 80'(k), 2'(k % 3), 3'(k % 8), "R1");
    cmd(4'd8, 0, 0, 0, 0, 80'hDEAD, 2'b00, 7, "R3");
    cmd(4'd1, 0, 0, 0, 0, '0, 0, 0, "R3");
    cmd(4'd0, 0, 0, 0, 0, '0, 0, 0, "R2");
    cmd(4'd1, 0, 0, 0, 0, '0, 0, 0, "R5");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      miscompares++;
      $display("FAIL R12: pending results actual %0d expected 0", sb.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule